// File: doc/BRIEF.md
# Toggle-Flop Single-Step Sequence Counter

This block is a 3-bit synchronous counter whose state is held in three toggle flip-flops. It does not count in binary. Each enabled rising clock edge moves it through a fixed eight-state loop in which exactly one state bit changes per step. From zero the loop runs 0, 4, 5, 7, 6, 2, 3, 1, and then returns to 0.

Combinational decode logic reads the present state and produces one toggle input per flip-flop. That decode comes from a transition table in which each toggle bit is the XOR of a present-state bit and the matching bit of its successor. While the count enable is low, the decode drives every toggle input to zero, so the state holds. A synchronous active-high reset returns the counter to zero.

Top module: `seqcnt_tff`

## Requirements
- R1: With `rst` high at a rising edge, `state` reads 0 after that edge, whatever its value was before, including a reset issued in the middle of the loop.
- R2: When `rst` and `en` are both high, reset wins and `state` is 0 after the edge.
- R3: With `rst` low and `en` high, starting from 0, successive edges give `state` values 4, 5, 7, 6, 2, 3, 1 in that order (bit 2 is the most significant bit).
- R4: An enabled edge taken in state 1 returns `state` to 0, so the eight-state loop repeats without end.
- R5: Every enabled edge without reset changes exactly one bit of `state`.
- R6: With `rst` low and `en` low, `state` keeps its value across any number of edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| state | output | 3 | Present counter state, bit 2 most significant |

## Verification
Every result of this block is due one rising edge after the inputs that cause it. A reset, a step and a hold each show up on `state` after the first edge that samples them. The bench changes `rst` and `en` on falling edges and advances its reference model on rising edges. It compares `state` with the model on the next falling edge, which is one edge after each stimulus. The single-bit check uses the state and enable captured at the previous rising edge, so it looks at exactly one transition at a time.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;

    localparam int CNT_W   = 3;
    localparam int SEQ_LEN = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t toggle;
        logic advance;
    } step_ctl_t;

    // Successor of each state in the single-bit-change loop.
    function automatic cnt_t succ(input cnt_t s);
        cnt_t n;
        case (s)
            3'd0:    n = 3'd4;
            3'd4:    n = 3'd5;
            3'd5:    n = 3'd7;
            3'd7:    n = 3'd6;
            3'd6:    n = 3'd2;
            3'd2:    n = 3'd3;
            3'd3:    n = 3'd1;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

    // Toggle inputs that take s to its successor.
    function automatic cnt_t toggle_mask(input cnt_t s);
        return s ^ succ(s);
    endfunction

endpackage

// File: rtl/seqcnt_tcell.sv
module seqcnt_tcell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic t,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= RST_VAL;
        else if (t)
            q_r <= ~q_r;
    end

    assign q = q_r;
endmodule

// File: rtl/seqcnt_decode.sv
module seqcnt_decode
    import seqcnt_pkg::*;
(
    input  cnt_t      cur,
    input  logic      en,
    output step_ctl_t ctl
);
    always_comb begin
        ctl.advance = en;
        ctl.toggle  = en ? toggle_mask(cur) : '0;
    end
endmodule

// File: rtl/seqcnt_tff.sv
module seqcnt_tff
    import seqcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] state
);
    cnt_t      cur_q;
    step_ctl_t ctl;

    seqcnt_decode u_dec (
        .cur (cur_q),
        .en  (en),
        .ctl (ctl)
    );

    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        seqcnt_tcell #(.RST_VAL(1'b0)) u_cell (
            .clk (clk),
            .rst (rst),
            .t   (ctl.toggle[b]),
            .q   (cur_q[b])
        );
    end

    assign state = cur_q;
endmodule

// File: rtl/seqcnt_chk.sv
module seqcnt_chk
    import seqcnt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] state
);
    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> state == '0);

    // R3
    first_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == 3'd0) |=> state == 3'd4);

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == 3'd1) |=> state == 3'd0);

    // R5
    one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> $countones(state ^ $past(state)) == 1);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));
endmodule

bind seqcnt_tff seqcnt_chk u_chk (.*);

// File: tb/tb_seqcnt_tff.sv
module tb_seqcnt_tff;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    int order [8] = '{0, 4, 5, 7, 6, 2, 3, 1};
    int idx = 0;
    logic [2:0] prev_state = '0;
    logic       prev_step  = 1'b0;
    logic       ref_valid  = 1'b0;

    seqcnt_tff dut (.clk(clk), .rst(rst), .en(en), .state(state));

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model: index into the loop
    always @(posedge clk) begin
        prev_state <= state;
        prev_step  <= en && !rst;
        ref_valid  <= 1'b1;
        if (rst)     idx <= 0;
        else if (en) idx <= (idx + 1) % 8;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (ref_valid) begin
            check(tag, int'(state), order[idx]);
            if (prev_step)
                check("R5", $countones(state ^ prev_state), 1);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input logic r, input logic e, input int n, input string t);
        @(negedge clk);
        rst = r;
        en  = e;
        tag = t;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        // R2: reset held with enable high
        drive(1'b1, 1'b1, 3, "R2");
        // R3 and R4: two full loops
        drive(1'b0, 1'b1, 17, "R3_R4");
        // R6: hold with enable low
        drive(1'b0, 1'b0, 6, "R6");
        drive(1'b0, 1'b1, 3, "R3");
        // R1: reset in the middle of the loop
        drive(1'b1, 1'b0, 1, "R1");
        drive(1'b0, 1'b1, 10, "R4");
        drive(1'b0, 1'b0, 3, "R6");
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule